// File: doc/BRIEF.md
# Angle-to-IQ Vector Amplitude Generator

This block turns a phase code and an amplitude code into the drive strengths for a pair of push-pull current outputs. The phase code selects one of 48 equally spaced directions around a full turn, 7.5 degrees apart. An internal quarter-wave table yields a signed cosine weight and a signed sine weight for that direction. Each weight is stored as a sign bit plus a 6-bit magnitude, with 63 standing for unity. Both weights are multiplied by the 8-bit amplitude code.

Four gate inputs decide which port each product reaches: in-phase forward and reverse, and quadrature forward and reverse. A forward gate sends a positive term to port A and a negative term to port B. A reverse gate does the opposite. Each port reports the sum of the terms that reach it, plus a flag that says the port is being driven. Both are registered one clock after the inputs. When the enable input is low, both ports are parked off.

Top module: `iq_vector_drive`

## Requirements
- R1: For codes 0 to 47 the cosine and sine magnitudes equal round(63*|cos(7.5°*code)|) and round(63*|sin(7.5°*code)|), with halves rounded up. Examples: code 1 gives 62/8, code 6 gives 45/45, code 12 gives 0/63 and code 47 gives 62/8.
- R2: The cosine sign is negative exactly for codes 13 to 36, and the sine sign is negative exactly for codes 25 to 47. The sign is kept on a zero magnitude, so code 36 has a negative zero cosine while codes 12 and 24 have positive zeros.
- R3: Code 48 behaves identically to code 0. Codes 49 to 63 give zero magnitudes with positive signs.
- R4: Each term magnitude is the amplitude code times the component magnitude, in the range 0 to 16065.
- R5: The in-phase term goes to port A when gate_i_fwd is high and the cosine is positive, or when gate_i_rev is high and the cosine is negative. It goes to port B in the two other combinations. The quadrature term is routed the same way, using the sine sign with gate_q_fwd and gate_q_rev.
- R6: A port magnitude is the sum of the term magnitudes routed to it. Its on flag is high whenever at least one term is routed to it, even a term of zero magnitude.
- R7: When enable is low, both port magnitudes are 0 and both on flags are low.
- R8: Outputs are registered. They reflect the inputs sampled at the previous rising clock edge and are all zero while rst_n is low.
- R9: The largest port magnitude is 22950. It is reached at code 6 with amplitude 255 and both forward gates high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Drive enable; low forces both ports off |
| angle_code | input | 6 | Phase step, 7.5 degrees each |
| amp_code | input | 8 | Amplitude scale |
| gate_i_fwd | input | 1 | In-phase gate, forward polarity |
| gate_i_rev | input | 1 | In-phase gate, reverse polarity |
| gate_q_fwd | input | 1 | Quadrature gate, forward polarity |
| gate_q_rev | input | 1 | Quadrature gate, reverse polarity |
| port_a_mag | output | 15 | Summed drive magnitude for port A |
| port_a_on | output | 1 | Port A is being driven |
| port_b_mag | output | 15 | Summed drive magnitude for port B |
| port_b_on | output | 1 | Port B is being driven |

## Verification
The bench sweeps all 64 phase codes against all sixteen gate patterns at several amplitudes. It computes the weights from floating-point trigonometry and the stated sign ranges. A table that drops the signed zeros at codes 12, 24 and 36 would set the wrong port's on flag. One that handles code 48 or the reserved codes badly would produce stray drive, and an off-by-one in the quadrant folding would swap cosine and sine magnitudes near the axes. Directed cases cover the 45-degree peak, the one-cycle latency, reset and the enable override, where a leak would leave current on a port that should be off.

// File: rtl/iqv_pkg.sv
package iqv_pkg;
  localparam int MAG_W   = 6;
  localparam int STEPS   = 48;
  localparam int QSTEPS  = STEPS / 4;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } vec_t;

  // Quarter-wave cosine magnitude, 63 = unity, index k = k*7.5 degrees.
  function automatic logic [MAG_W-1:0] quarter_mag(input logic [3:0] k);
    case (k)
      4'd0:    quarter_mag = 6'd63;
      4'd1:    quarter_mag = 6'd62;
      4'd2:    quarter_mag = 6'd61;
      4'd3:    quarter_mag = 6'd58;
      4'd4:    quarter_mag = 6'd55;
      4'd5:    quarter_mag = 6'd50;
      4'd6:    quarter_mag = 6'd45;
      4'd7:    quarter_mag = 6'd38;
      4'd8:    quarter_mag = 6'd32;
      4'd9:    quarter_mag = 6'd24;
      4'd10:   quarter_mag = 6'd16;
      4'd11:   quarter_mag = 6'd8;
      default: quarter_mag = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/iqv_angle_lut.sv
module iqv_angle_lut
  import iqv_pkg::*;
#(
  parameter int ANGLE_W = 6
) (
  input  logic [ANGLE_W-1:0] angle,
  output vec_t               cos_v,
  output vec_t               sin_v,
  output logic               code_valid
);
  localparam logic [ANGLE_W-1:0] WRAP = ANGLE_W'(STEPS);
  localparam logic [ANGLE_W-1:0] Q1   = ANGLE_W'(QSTEPS);
  localparam logic [ANGLE_W-1:0] Q2   = ANGLE_W'(2 * QSTEPS);
  localparam logic [ANGLE_W-1:0] Q3   = ANGLE_W'(3 * QSTEPS);

  logic [ANGLE_W-1:0] eff;
  logic [ANGLE_W-1:0] base;
  logic [1:0]         quad;
  logic [3:0]         rem;
  logic [3:0]         rem_c;

  always_comb begin
    code_valid = (angle <= WRAP);
    eff        = (angle == WRAP) ? '0 : angle;
    if (eff < Q1)      begin quad = 2'd0; base = '0; end
    else if (eff < Q2) begin quad = 2'd1; base = Q1; end
    else if (eff < Q3) begin quad = 2'd2; base = Q2; end
    else               begin quad = 2'd3; base = Q3; end
    rem   = 4'(eff - base);
    rem_c = 4'(QSTEPS) - rem;

    unique case (quad)
      2'd0: begin cos_v.mag = quarter_mag(rem);   sin_v.mag = quarter_mag(rem_c); end
      2'd1: begin cos_v.mag = quarter_mag(rem_c); sin_v.mag = quarter_mag(rem);   end
      2'd2: begin cos_v.mag = quarter_mag(rem);   sin_v.mag = quarter_mag(rem_c); end
      default: begin cos_v.mag = quarter_mag(rem_c); sin_v.mag = quarter_mag(rem); end
    endcase
    // Half-plane sign rule; signs persist on zero magnitudes.
    cos_v.neg = (eff > Q1) && (eff <= Q3);
    sin_v.neg = (eff > Q2);

    if (!code_valid) begin
      cos_v = '0;
      sin_v = '0;
    end
  end
endmodule

// File: rtl/iqv_term.sv
module iqv_term
  import iqv_pkg::*;
#(
  parameter int AMP_W  = 8,
  parameter int PROD_W = AMP_W + MAG_W
) (
  input  vec_t              vec,
  input  logic [AMP_W-1:0]  amp,
  input  logic              gate_fwd,
  input  logic              gate_rev,
  output logic [PROD_W-1:0] prod,
  output logic              to_a,
  output logic              to_b
);
  function automatic logic [PROD_W-1:0] scale(input logic [AMP_W-1:0] a,
                                               input logic [MAG_W-1:0] m);
    scale = PROD_W'(a) * PROD_W'(m);
  endfunction

  always_comb begin
    prod = scale(amp, vec.mag);
    to_a = (gate_fwd && !vec.neg) || (gate_rev && vec.neg);
    to_b = (gate_fwd && vec.neg)  || (gate_rev && !vec.neg);
  end
endmodule

// File: rtl/iqv_port_sum.sv
module iqv_port_sum #(
  parameter int PROD_W = 14,
  parameter int NTERM  = 2,
  parameter int SUM_W  = PROD_W + $clog2(NTERM)
) (
  input  logic [NTERM-1:0][PROD_W-1:0] prod,
  input  logic [NTERM-1:0]             sel,
  output logic [SUM_W-1:0]             sum,
  output logic                         any
);
  always_comb begin
    sum = '0;
    for (int t = 0; t < NTERM; t++) begin
      if (sel[t]) sum = sum + SUM_W'(prod[t]);
    end
    any = |sel;
  end
endmodule

// File: rtl/iq_vector_drive.sv
module iq_vector_drive
  import iqv_pkg::*;
#(
  parameter int ANGLE_W = 6,
  parameter int AMP_W   = 8,
  parameter int PROD_W  = AMP_W + MAG_W,
  parameter int SUM_W   = PROD_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [ANGLE_W-1:0] angle_code,
  input  logic [AMP_W-1:0]   amp_code,
  input  logic               gate_i_fwd,
  input  logic               gate_i_rev,
  input  logic               gate_q_fwd,
  input  logic               gate_q_rev,
  output logic [SUM_W-1:0]   port_a_mag,
  output logic               port_a_on,
  output logic [SUM_W-1:0]   port_b_mag,
  output logic               port_b_on
);
  localparam int NTERM = 2;
  localparam int NPORT = 2;

  vec_t                         lut_cos;
  vec_t                         lut_sin;
  logic                         code_valid;
  vec_t [NTERM-1:0]             term_vec;
  logic [NTERM-1:0]             term_fwd;
  logic [NTERM-1:0]             term_rev;
  logic [NTERM-1:0][PROD_W-1:0] term_prod;
  logic [NPORT-1:0][NTERM-1:0]  term_sel;
  logic [NPORT-1:0][SUM_W-1:0]  port_sum;
  logic [NPORT-1:0]             port_any;

  iqv_angle_lut #(.ANGLE_W(ANGLE_W)) lut_i (
    .angle      (angle_code),
    .cos_v      (lut_cos),
    .sin_v      (lut_sin),
    .code_valid (code_valid)
  );

  assign term_vec = {lut_sin, lut_cos};
  assign term_fwd = {gate_q_fwd, gate_i_fwd};
  assign term_rev = {gate_q_rev, gate_i_rev};

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    iqv_term #(.AMP_W(AMP_W), .PROD_W(PROD_W)) term_i (
      .vec      (term_vec[t]),
      .amp      (amp_code),
      .gate_fwd (term_fwd[t]),
      .gate_rev (term_rev[t]),
      .prod     (term_prod[t]),
      .to_a     (term_sel[0][t]),
      .to_b     (term_sel[1][t])
    );
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    iqv_port_sum #(.PROD_W(PROD_W), .NTERM(NTERM), .SUM_W(SUM_W)) sum_i (
      .prod (term_prod),
      .sel  (term_sel[p]),
      .sum  (port_sum[p]),
      .any  (port_any[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_a_mag <= '0;
      port_a_on  <= 1'b0;
      port_b_mag <= '0;
      port_b_on  <= 1'b0;
    end else if (!enable) begin
      port_a_mag <= '0;
      port_a_on  <= 1'b0;
      port_b_mag <= '0;
      port_b_on  <= 1'b0;
    end else begin
      port_a_mag <= port_sum[0];
      port_a_on  <= port_any[0];
      port_b_mag <= port_sum[1];
      port_b_on  <= port_any[1];
    end
  end
endmodule

// File: rtl/iqv_checker.sv
module iqv_checker
  import iqv_pkg::*;
#(
  parameter int ANGLE_W = 6,
  parameter int AMP_W   = 8,
  parameter int SUM_W   = AMP_W + MAG_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic [ANGLE_W-1:0] angle_code,
  input logic               gate_i_fwd,
  input logic               gate_i_rev,
  input logic               gate_q_fwd,
  input logic               gate_q_rev,
  input logic [MAG_W-1:0]   cos_mag,
  input logic [MAG_W-1:0]   sin_mag,
  input logic [SUM_W-1:0]   port_a_mag,
  input logic               port_a_on,
  input logic [SUM_W-1:0]   port_b_mag,
  input logic               port_b_on
);
  localparam int PEAK = ((1 << AMP_W) - 1) * 2 * int'(quarter_mag(4'd6));

  logic primed;
  logic gates_idle;
  assign gates_idle = !(gate_i_fwd || gate_i_rev || gate_q_fwd || gate_q_rev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(enable)) |->
      (port_a_mag == '0 && port_b_mag == '0 && !port_a_on && !port_b_on)); // R7

  AST_IDLE_GATES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(gates_idle)) |->
      (port_a_mag == '0 && port_b_mag == '0 && !port_a_on && !port_b_on)); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (angle_code > ANGLE_W'(STEPS)) |-> (cos_mag == '0 && sin_mag == '0)); // R3

  AST_A_FLAG_WITH_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    (port_a_mag != '0) |-> port_a_on); // R6

  AST_B_FLAG_WITH_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    (port_b_mag != '0) |-> port_b_on); // R6

  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(port_a_mag) <= PEAK) && (int'(port_b_mag) <= PEAK)); // R9
endmodule

bind iq_vector_drive iqv_checker #(
  .ANGLE_W (ANGLE_W),
  .AMP_W   (AMP_W),
  .SUM_W   (SUM_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .angle_code (angle_code),
  .gate_i_fwd (gate_i_fwd),
  .gate_i_rev (gate_i_rev),
  .gate_q_fwd (gate_q_fwd),
  .gate_q_rev (gate_q_rev),
  .cos_mag    (lut_cos.mag),
  .sin_mag    (lut_sin.mag),
  .port_a_mag (port_a_mag),
  .port_a_on  (port_a_on),
  .port_b_mag (port_b_mag),
  .port_b_on  (port_b_on)
);

// File: tb/iq_vector_drive_tb.sv
module iq_vector_drive_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic [5:0]  angle_code = 6'd6;
  logic [7:0]  amp_code = 8'd255;
  logic        gate_i_fwd = 1'b1, gate_i_rev = 1'b1, gate_q_fwd = 1'b1, gate_q_rev = 1'b1;
  logic [14:0] port_a_mag, port_b_mag;
  logic        port_a_on, port_b_on;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  iq_vector_drive dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .angle_code(angle_code),
    .amp_code(amp_code), .gate_i_fwd(gate_i_fwd), .gate_i_rev(gate_i_rev),
    .gate_q_fwd(gate_q_fwd), .gate_q_rev(gate_q_rev),
    .port_a_mag(port_a_mag), .port_a_on(port_a_on),
    .port_b_mag(port_b_mag), .port_b_on(port_b_on)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rmag(input real x);
    real ax;
    ax = (x < 0.0) ? -x : x;
    return int'($floor(63.0 * ax + 0.5 + 1.0e-9));
  endfunction

  // Expected outputs from the requirements: {a_mag, a_on, b_mag, b_on}
  task automatic model(input int code, input int amp, input bit en, input bit [3:0] g,
                       output int am, output int ao, output int bm, output int bo);
    int cm, sm, e;
    bit cn, sn, ia, ib, qa, qb;
    real ang;
    if (code > 48) begin cm = 0; sm = 0; cn = 0; sn = 0; end
    else begin
      e   = (code == 48) ? 0 : code;
      ang = real'(e) * 7.5 * 3.14159265358979323846 / 180.0;
      cm  = rmag($cos(ang));
      sm  = rmag($sin(ang));
      cn  = (e >= 13 && e <= 36);
      sn  = (e >= 25);
    end
    {ia, ib, qa, qb} = g;
    am = 0; bm = 0; ao = 0; bo = 0;
    if ((ia && !cn) || (ib && cn)) begin am += amp * cm; ao = 1; end
    if ((ia && cn) || (ib && !cn)) begin bm += amp * cm; bo = 1; end
    if ((qa && !sn) || (qb && sn)) begin am += amp * sm; ao = 1; end
    if ((qa && sn) || (qb && !sn)) begin bm += amp * sm; bo = 1; end
    if (!en) begin am = 0; bm = 0; ao = 0; bo = 0; end
  endtask

  task automatic drive(input int code, input int amp, input bit en, input bit [3:0] g);
    angle_code = 6'(code);
    amp_code   = 8'(amp);
    enable     = en;
    {gate_i_fwd, gate_i_rev, gate_q_fwd, gate_q_rev} = g;
  endtask

  task automatic run(input string tag, input int code, input int amp, input bit en,
                     input bit [3:0] g);
    int am, ao, bm, bo;
    @(negedge clk);
    drive(code, amp, en, g);
    @(negedge clk);
    model(code, amp, en, g, am, ao, bm, bo);
    chk({tag, " a_mag"}, int'(port_a_mag), am);
    chk({tag, " a_on"},  int'(port_a_on),  ao);
    chk({tag, " b_mag"}, int'(port_b_mag), bm);
    chk({tag, " b_on"},  int'(port_b_on),  bo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int amps[5] = '{0, 1, 77, 200, 255};
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state with busy inputs
    chk("R8 reset a_mag", int'(port_a_mag), 0);
    chk("R8 reset a_on", int'(port_a_on), 0);
    chk("R8 reset b_mag", int'(port_b_mag), 0);
    chk("R8 reset b_on", int'(port_b_on), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed cases
    run("R1 code1", 1, 1, 1, 4'b1000);
    chk("R1 code1 cos62", int'(port_a_mag), 62);
    run("R1 code1 sin", 1, 1, 1, 4'b0010);
    chk("R1 code1 sin8", int'(port_a_mag), 8);
    run("R2 code36 neg zero", 36, 200, 1, 4'b1000);
    chk("R2 code36 to B", int'(port_b_on), 1);
    chk("R2 code36 not A", int'(port_a_on), 0);
    run("R2 code24 pos zero", 24, 200, 1, 4'b0010);
    chk("R2 code24 sine to A", int'(port_a_on), 1);
    run("R3 code48", 48, 123, 1, 4'b1010);
    chk("R3 code48 like 0", int'(port_a_mag), 123 * 63);
    run("R3 code55", 55, 255, 1, 4'b1111);
    chk("R3 reserved zero", int'(port_a_mag) + int'(port_b_mag), 0);
    run("R4 code12", 12, 255, 1, 4'b0010);
    chk("R4 full product", int'(port_a_mag), 16065);
    run("R5 code24 fwd", 24, 10, 1, 4'b1000);
    chk("R5 neg cos to B", int'(port_b_mag), 630);
    run("R6 code6 sum", 6, 10, 1, 4'b1010);
    chk("R6 sum", int'(port_a_mag), 900);
    run("R7 disabled", 6, 255, 0, 4'b1111);
    chk("R7 off", int'(port_a_on) + int'(port_b_on), 0);
    run("R9 peak", 6, 255, 1, 4'b1010);
    chk("R9 peak value", int'(port_a_mag), 22950);

    // R8 latency: output holds the prior result until the next edge
    @(negedge clk);
    drive(12, 100, 1, 4'b0010);
    @(negedge clk);
    drive(0, 50, 1, 4'b1000);
    #2;
    chk("R8 hold before edge", int'(port_a_mag), 6300);
    @(negedge clk);
    chk("R8 update after edge", int'(port_a_mag), 3150);

    // Sweep: every code, every gate pattern, several amplitudes
    for (int c = 0; c < 64; c++) begin
      for (int ai = 0; ai < 5; ai++) begin
        for (int g = 0; g < 16; g++) begin
          run((c > 47) ? "R3 sweep" : "R1 sweep", c, amps[ai], 1, 4'(g));
        end
      end
      run("R7 sweep", c, 255, 0, 4'b1111);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule